// File: doc/BRIEF.md
# Programmable Bus Wait-State Generator

This block stretches selected bus accesses by holding a ready request low for a chosen number of clocks. An internal chain of flip-flops is kept cleared while the bus is idle. The bus is idle when the read, write and interrupt-acknowledge strobes (all active low) are all high. Once any of those strobes goes low, every rising clock edge moves a logic 1 one position further along the chain. A tap-select input picks which chain position drives the ready path. That choice sets how many wait states the access receives.

The ready request is forced high when the device select (active low) is high, so only accesses to a device that needs them are slowed. Tap value 0 switches wait insertion off. Tap values above the chain length minus one are clamped to the longest available delay. When the chosen position fills, the ready request rises and stays high until the strobes return to idle, which clears the chain for the next access.

Top module: `wsg_gen`

## Requirements
- R1: While at least one strobe is low, each rising clock edge sets one more chain position, filling from position 0 upward. After k edges, exactly positions 0 to k-1 are 1.
- R2: While all three strobes are high, `rdy_req` is 1 and the chain returns to all zeros at the next rising edge. A new access therefore always starts its count from zero.
- R3: With `sel_n` = 0 and `tap_sel` = w for w from 1 to SR_LEN-1, `rdy_req` is 0 from the moment a strobe goes low until the (w+1)-th rising edge after that moment. It is 1 from that edge on, which gives w wait states.
- R4: Any `tap_sel` value of SR_LEN or more behaves exactly like SR_LEN-1. With the default SR_LEN of 8, that is 7 wait states.
- R5: While `sel_n` = 1, `rdy_req` is 1.
- R6: While `tap_sel` = 0, `rdy_req` is 1.
- R7: Once `rdy_req` has risen during an access, it stays 1 until the strobes go idle, as long as `sel_n` and `tap_sel` are held steady.
- R8: Each of `rd_n`, `wr_n` and `inta_n` on its own starts the wait sequence with identical timing.
- R9: An active-low `rst_n` clears the chain at once, without waiting for a clock edge. If a strobe is still low after reset is released, counting restarts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; the chain advances on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| inta_n | input | 1 | Interrupt-acknowledge strobe, active low |
| sel_n | input | 1 | Device select, active low; only a selected device is slowed |
| tap_sel | input | TAP_W | Requested wait count; 0 means no waits |
| rdy_req | output | 1 | Ready request toward the processor's ready input |

## Verification
The ready request is combinational from the chain and the inputs. Its level right after a strobe goes low is therefore due within the same clock period, and the bench samples it 1 ns after driving the strobe. After that, the output may change only at rising edges. The bench counts rising edges k since the strobe fell, samples at the following falling edge, and expects a high level exactly when k is at least the clamped tap value plus one. The return to high when the strobes go idle is due at once, and the chain clear is due at the next rising edge. The bench confirms that clear by starting a fresh access one edge later and expecting the full count again.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
   // Combined idle condition of the three active-low bus strobes.
   function automatic logic bus_idle(input logic rd_n, input logic wr_n, input logic inta_n);
      return rd_n & wr_n & inta_n;
   endfunction
endpackage

// File: rtl/wsg_tap_decode.sv
module wsg_tap_decode #(
   parameter int SR_LEN = 8,
   parameter int TAP_W  = 4,
   localparam int IDX_W = $clog2(SR_LEN)
) (
   input  logic [TAP_W-1:0] tap_sel,
   output logic [IDX_W-1:0] tap_idx,
   output logic             waits_en
);
   localparam bit NEED_CLAMP = ((2 ** TAP_W) > SR_LEN);

   assign waits_en = (tap_sel != '0);

   generate
      if (NEED_CLAMP) begin : g_clamp
         localparam logic [TAP_W-1:0] MAX_TAP = TAP_W'(SR_LEN - 1);
         always_comb begin
            if (tap_sel > MAX_TAP) tap_idx = IDX_W'(SR_LEN - 1);
            else                   tap_idx = IDX_W'(tap_sel);
         end
      end else begin : g_direct
         assign tap_idx = IDX_W'(tap_sel);
      end
   endgenerate
endmodule

// File: rtl/wsg_shift_chain.sv
module wsg_shift_chain #(
   parameter int SR_LEN = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              idle,
   output logic [SR_LEN-1:0] chain
);
   genvar j;
   generate
      for (j = 0; j < SR_LEN; j++) begin : g_stage
         logic d_in;
         if (j == 0) begin : g_head
            assign d_in = 1'b1;
         end else begin : g_body
            assign d_in = chain[j-1];
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    chain[j] <= 1'b0;
            else if (idle) chain[j] <= 1'b0;
            else           chain[j] <= d_in;
         end

         if (j > 0) begin : g_thermo
            // R1: a position is never set ahead of the one before it
            assert_thermometer_R1: assert property (@(posedge clk) disable iff (!rst_n)
               chain[j] |-> chain[j-1]);
         end
      end
   endgenerate

   // R2: idle bus clears the whole chain by the next edge
   assert_idle_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      idle |=> (chain == '0));

   // R1: an active strobe always seeds position 0
   assert_head_fills_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !idle |=> chain[0]);
endmodule

// File: rtl/wsg_ready_mux.sv
module wsg_ready_mux #(
   parameter int SR_LEN = 8,
   localparam int IDX_W = $clog2(SR_LEN)
) (
   input  logic [SR_LEN-1:0] chain,
   input  logic [IDX_W-1:0]  tap_idx,
   input  logic              waits_en,
   input  logic              idle,
   input  logic              sel_n,
   output logic              rdy_req
);
   logic tapped;
   assign tapped  = chain[tap_idx];
   assign rdy_req = idle | sel_n | ~waits_en | tapped;
endmodule

// File: rtl/wsg_gen.sv
module wsg_gen #(
   parameter int SR_LEN = 8,
   parameter int TAP_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_n,
   input  logic             wr_n,
   input  logic             inta_n,
   input  logic             sel_n,
   input  logic [TAP_W-1:0] tap_sel,
   output logic             rdy_req
);
   import wsg_pkg::*;

   localparam int IDX_W = $clog2(SR_LEN);

   generate
      if (SR_LEN < 2) begin : g_bad_len
         $error("wsg_gen: SR_LEN must be at least 2");
      end
      if ((2 ** TAP_W) < SR_LEN) begin : g_bad_tap
         $error("wsg_gen: TAP_W too narrow to reach every chain position");
      end
   endgenerate

   logic              idle;
   logic [SR_LEN-1:0] chain;
   logic [IDX_W-1:0]  tap_idx;
   logic              waits_en;

   assign idle = bus_idle(rd_n, wr_n, inta_n);

   wsg_tap_decode #(.SR_LEN(SR_LEN), .TAP_W(TAP_W)) u_decode (
      .tap_sel  (tap_sel),
      .tap_idx  (tap_idx),
      .waits_en (waits_en)
   );

   wsg_shift_chain #(.SR_LEN(SR_LEN)) u_chain (
      .clk   (clk),
      .rst_n (rst_n),
      .idle  (idle),
      .chain (chain)
   );

   wsg_ready_mux #(.SR_LEN(SR_LEN)) u_mux (
      .chain    (chain),
      .tap_idx  (tap_idx),
      .waits_en (waits_en),
      .idle     (idle),
      .sel_n    (sel_n),
      .rdy_req  (rdy_req)
   );

   // R2: idle strobes always present ready
   assert_idle_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_n && wr_n && inta_n) |-> rdy_req);

   // R5: deselected device is never slowed
   assert_unselected_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sel_n |-> rdy_req);

   // R6: tap value zero disables waits
   assert_tap_zero_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tap_sel == '0) |-> rdy_req);

   // R7: ready never drops again within one access
   assert_ready_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle && rdy_req) |=> (idle || !$stable(sel_n) || !$stable(tap_sel) || rdy_req));
endmodule

// File: tb/wsg_gen_tb.sv
module wsg_gen_tb;
   localparam int SR_LEN = 8;
   localparam int TAP_W  = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             rd_n = 1'b1;
   logic             wr_n = 1'b1;
   logic             inta_n = 1'b1;
   logic             sel_n = 1'b0;
   logic [TAP_W-1:0] tap_sel = '0;
   logic             rdy_req;

   int n_chk  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   wsg_gen #(.SR_LEN(SR_LEN), .TAP_W(TAP_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n),
      .sel_n(sel_n), .tap_sel(tap_sel), .rdy_req(rdy_req)
   );

   task automatic chk(input logic act, input logic exp, input string req, input string ctx);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%b expected=%b", req, ctx, act, exp);
      end
   endtask

   function automatic int waits_for(input int tap);
      if (tap >= SR_LEN) return SR_LEN - 1;
      return tap;
   endfunction

   task automatic set_strobe(input int kind, input logic lvl);
      case (kind)
         0: rd_n = lvl;
         1: wr_n = lvl;
         default: inta_n = lvl;
      endcase
   endtask

   // One access of the given kind (R8), checking every cycle for 12 edges.
   task automatic run_access(input int kind, input logic sel, input int tap);
      int w;
      logic exp;
      string req;
      @(negedge clk);
      rd_n = 1'b1; wr_n = 1'b1; inta_n = 1'b1;
      sel_n = sel;
      tap_sel = TAP_W'(tap);
      @(posedge clk);
      @(negedge clk);
      chk(rdy_req, 1'b1, "R2", "idle before access");
      w = waits_for(tap);
      set_strobe(kind, 1'b0);
      for (int k = 0; k < 12; k++) begin
         if (k > 0) begin
            @(posedge clk);
            @(negedge clk);
         end else begin
            #1;
         end
         exp = sel | (tap == 0) | (k >= w + 1);
         if (tap == 0)        req = "R6";
         else if (sel)        req = "R5";
         else if (k > w + 1)  req = "R7";
         else if (tap >= SR_LEN) req = "R4";
         else                 req = "R3";
         chk(rdy_req, exp, req,
             $sformatf("kind=%0d sel=%0b tap=%0d edges=%0d", kind, sel, tap, k));
      end
      set_strobe(kind, 1'b1);
      #1;
      chk(rdy_req, 1'b1, "R2", "strobe released");
   endtask

   initial begin
      #2_000_000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      // Reset state
      repeat (2) @(negedge clk);
      chk(rdy_req, 1'b1, "R2", "during reset, bus idle");
      rst_n = 1'b1;

      // Sweep: every strobe (R8), select level (R5), tap value (R3 R4 R6 R7)
      for (int kind = 0; kind < 3; kind++)
         for (int s = 0; s < 2; s++)
            for (int t = 0; t < 16; t++)
               run_access(kind, s[0], t);

      // R2: drop strobes mid-count for one edge; count must restart from zero
      @(negedge clk);
      sel_n = 1'b0; tap_sel = 4'd5;
      rd_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rd_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr_n = 1'b0;
      for (int k = 0; k < 8; k++) begin
         if (k > 0) begin
            @(posedge clk);
            @(negedge clk);
         end else begin
            #1;
         end
         chk(rdy_req, (k >= 6), "R2", $sformatf("restart after idle edges=%0d", k));
      end
      wr_n = 1'b1;

      // R9: reset mid-access clears the chain asynchronously
      @(negedge clk);
      tap_sel = 4'd3;
      inta_n = 1'b0;
      repeat (5) @(posedge clk);
      @(negedge clk);
      chk(rdy_req, 1'b1, "R3", "before reset, count done");
      rst_n = 1'b0;
      #1;
      chk(rdy_req, 1'b0, "R9", "async clear while strobe low");
      @(negedge clk);
      rst_n = 1'b1;
      for (int k = 0; k < 6; k++) begin
         if (k > 0) begin
            @(posedge clk);
            @(negedge clk);
         end
         chk(rdy_req, (k >= 4), "R9", $sformatf("count after reset edges=%0d", k));
      end
      inta_n = 1'b1;
      #1;
      chk(rdy_req, 1'b1, "R2", "final idle");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule